// File: doc/BRIEF.md
# Four-Channel Programmable Interval Timer

This peripheral holds four independent counting channels behind one synchronous register bus. Each channel advances on its own single-cycle tick enable, so one block can serve a slow operating-system tick, a millisecond tick and two microsecond timebases at once. A channel counts up toward a programmable limit. When it reaches the limit it latches a pending event. In repeat mode it then restarts from zero; in single-event mode it stops and goes idle. Each channel drives its own interrupt line, and software clears the pending event by writing to an acknowledge register.

Control is by action-on-write: writing any value to a channel's clear, start or stop register performs that action. A packed status word reports the run state, the mode, the interrupt enable and the pending flag. A shared control register at address 0x100 gates tick delivery to all four channels.

The bus has no handshake and no back-pressure. A write takes effect at the clock edge where `bus_wr_i` is high. Reads are combinational on `bus_addr_i`. Ticks are single-cycle enables, and no tick is ever stalled or queued.

Top module: `quad_tick_timer`

## Requirements
- R1: Channel c occupies a 64-byte group at base c*0x40. Within the group, reads return the status word at +0x10, the count at +0x14 and the limit at +0x18, all zero-extended. Reads of the write-only registers, of unused offsets and of any unmapped address return zero.
- R2: A write of any data to +0x04 (start) sets the run indicator. A write of any data to +0x08 (stop) clears it. While the channel is stopped, its count does not change.
- R3: While the channel is running and the shared tick gate is open, each tick enable adds one to the count.
- R4: A write of any data to +0x00 (clear) zeroes the count and the pending flag. It leaves the mode, the limit, the run state and the interrupt enable unchanged, and it takes priority over a tick in the same cycle.
- R5: In repeat mode (mode register +0x0C bit 0 = 0), the tick that brings the count to the limit sets the pending flag and returns the count to 0. The channel keeps running.
- R6: In single-event mode (+0x0C bit 0 = 1), the tick that brings the count to the limit sets the pending flag and leaves the count at the limit. The channel becomes idle with its run indicator clear, and later ticks have no effect.
- R7: A limit of 1 produces an event on the first tick after start.
- R8: The status word holds the state in bits [3:0] (1 = idle, 2 = running), the run indicator in bit 4, single-event mode in bit 5, the interrupt enable in bit 6 and pending in bit 7. All upper bits are zero.
- R9: Bit 0 of +0x1C sets the interrupt enable. Each channel's `irq_o` bit is high exactly when that channel is pending and its interrupt is enabled.
- R10: A write to +0x20 with bit 7 set clears pending. A write to +0x20 with bit 7 clear has no effect. If a limit hit occurs in the same cycle as the acknowledge, the channel stays pending.
- R11: With the limit at all ones (the reset value) and repeat mode selected, the channel runs freely, wraps to 0 and keeps counting.
- R12: Bit 0 of the register at 0x100 (reset value 0) opens the tick gate for all channels. While the gate is closed, all ticks are ignored.
- R13: Channels are independent. Ticks and writes for one channel leave the count and the flags of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | NUM_CH | Per-channel single-cycle tick enables |
| bus_addr_i | input | ADDR_W | Register byte address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i |
| irq_o | output | NUM_CH | Per-channel interrupt |

## Verification
The bench targets the cycle where a tick lands on the limit. A design that compares the count before incrementing would fire one tick late, and with a limit of 1 it would skip the first event entirely. The bench drives an acknowledge in the same cycle as a fresh limit hit; a design that lets the acknowledge win would lose that event. It also checks that an acknowledge without bit 7 is ignored, that clear keeps the mode and limit, and that a single-event channel ignores ticks after it fires. It also runs a narrowed counter through its all-ones wrap, where a design that stops or saturates would show a frozen count.

// File: rtl/qtt_pkg.sv
`timescale 1ns/1ps
package qtt_pkg;
  localparam int GRP_W = 6;
  localparam logic [GRP_W-1:0] OFS_CLEAR = 6'h00;
  localparam logic [GRP_W-1:0] OFS_START = 6'h04;
  localparam logic [GRP_W-1:0] OFS_STOP  = 6'h08;
  localparam logic [GRP_W-1:0] OFS_MODE  = 6'h0C;
  localparam logic [GRP_W-1:0] OFS_STAT  = 6'h10;
  localparam logic [GRP_W-1:0] OFS_COUNT = 6'h14;
  localparam logic [GRP_W-1:0] OFS_LIMIT = 6'h18;
  localparam logic [GRP_W-1:0] OFS_IEN   = 6'h1C;
  localparam logic [GRP_W-1:0] OFS_ACK   = 6'h20;
  localparam logic [3:0] ST_IDLE = 4'd1;
  localparam logic [3:0] ST_RUN  = 4'd2;
  localparam int ACK_BIT = 7;

  typedef struct packed {
    logic clear;
    logic start;
    logic stop;
    logic mode;
    logic limit;
    logic ien;
    logic ack;
  } cmd_t;

  typedef struct packed {
    logic       pend;
    logic       ien;
    logic       oneshot;
    logic       run;
    logic [3:0] state;
  } stat_t;
endpackage

// File: rtl/qtt_addr_decode.sv
`timescale 1ns/1ps
module qtt_addr_decode import qtt_pkg::*; #(
  parameter int ADDR_W = 12,
  parameter int NUM_CH = 4
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  output cmd_t [NUM_CH-1:0]  cmd_o,
  output logic [NUM_CH-1:0]  ch_sel_o,
  output logic               ctl_sel_o,
  output logic [GRP_W-1:0]   ofs_o
);
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int SPAN_W = GRP_W + CH_W;
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NUM_CH) << GRP_W;

  logic in_span;
  assign in_span   = (addr_i >> SPAN_W) == '0;
  assign ofs_o     = addr_i[GRP_W-1:0];
  assign ctl_sel_o = addr_i == CTL_ADDR;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic wr_c;
    assign ch_sel_o[c]     = in_span && (addr_i[GRP_W +: CH_W] == CH_W'(c));
    assign wr_c            = wr_i && ch_sel_o[c];
    assign cmd_o[c].clear  = wr_c && (ofs_o == OFS_CLEAR);
    assign cmd_o[c].start  = wr_c && (ofs_o == OFS_START);
    assign cmd_o[c].stop   = wr_c && (ofs_o == OFS_STOP);
    assign cmd_o[c].mode   = wr_c && (ofs_o == OFS_MODE);
    assign cmd_o[c].limit  = wr_c && (ofs_o == OFS_LIMIT);
    assign cmd_o[c].ien    = wr_c && (ofs_o == OFS_IEN);
    assign cmd_o[c].ack    = wr_c && (ofs_o == OFS_ACK);
  end
endmodule

// File: rtl/qtt_channel.sv
`timescale 1ns/1ps
module qtt_channel import qtt_pkg::*; #(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              gate_i,
  input  cmd_t              cmd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  limit_o,
  output stat_t             stat_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] cnt_q, limit_q, cnt_inc;
  logic run_q, oneshot_q, ien_q, pend_q;
  logic step, hit;

  assign step    = tick_i && gate_i && run_q;
  assign cnt_inc = cnt_q + CNT_W'(1);
  assign hit     = step && (cnt_inc == limit_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      limit_q   <= '1;
      run_q     <= 1'b0;
      oneshot_q <= 1'b0;
      ien_q     <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      if (step) begin
        if (hit) begin
          pend_q <= 1'b1;
          if (oneshot_q) begin
            cnt_q <= cnt_inc;
            run_q <= 1'b0;
          end else begin
            cnt_q <= '0;
          end
        end else begin
          cnt_q <= cnt_inc;
        end
      end
      if (cmd_i.start) run_q     <= 1'b1;
      if (cmd_i.stop)  run_q     <= 1'b0;
      if (cmd_i.mode)  oneshot_q <= wdata_i[0];
      if (cmd_i.limit) limit_q   <= wdata_i[CNT_W-1:0];
      if (cmd_i.ien)   ien_q     <= wdata_i[0];
      if (cmd_i.ack && wdata_i[ACK_BIT] && !hit) pend_q <= 1'b0;
      if (cmd_i.clear) begin
        cnt_q  <= '0;
        pend_q <= 1'b0;
      end
    end
  end

  assign cnt_o          = cnt_q;
  assign limit_o        = limit_q;
  assign stat_o.pend    = pend_q;
  assign stat_o.ien     = ien_q;
  assign stat_o.oneshot = oneshot_q;
  assign stat_o.run     = run_q;
  assign stat_o.state   = run_q ? ST_RUN : ST_IDLE;
  assign irq_o          = pend_q && ien_q;

  p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cmd_i.clear) |=> (cnt_q == $past(cnt_q)));
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !hit && !cmd_i.clear) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i.clear |=> (cnt_q == '0 && !pend_q));
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !oneshot_q && !cmd_i.clear) |=> (cnt_q == '0 && pend_q));
  p_oneshot_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && oneshot_q && !cmd_i.start) |=> !run_q);
  p_hit_beats_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !cmd_i.clear) |=> pend_q);
endmodule

// File: rtl/quad_tick_timer.sv
`timescale 1ns/1ps
module quad_tick_timer import qtt_pkg::*; #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] tick_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  localparam int STAT_W = $bits(stat_t);

  cmd_t  [NUM_CH-1:0]            cmd_w;
  logic  [NUM_CH-1:0]            ch_sel_w;
  logic                          ctl_sel_w;
  logic  [GRP_W-1:0]             ofs_w;
  logic  [NUM_CH-1:0][CNT_W-1:0] cnt_w, limit_w;
  stat_t [NUM_CH-1:0]            stat_w;
  logic                          gate_q;

  qtt_addr_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) dec_i (
    .addr_i   (bus_addr_i),
    .wr_i     (bus_wr_i),
    .cmd_o    (cmd_w),
    .ch_sel_o (ch_sel_w),
    .ctl_sel_o(ctl_sel_w),
    .ofs_o    (ofs_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                      gate_q <= 1'b0;
    else if (bus_wr_i && ctl_sel_w)  gate_q <= bus_wdata_i[0];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    qtt_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W)) ch_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i[c]),
      .gate_i (gate_q),
      .cmd_i  (cmd_w[c]),
      .wdata_i(bus_wdata_i),
      .cnt_o  (cnt_w[c]),
      .limit_o(limit_w[c]),
      .stat_o (stat_w[c]),
      .irq_o  (irq_o[c])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (ctl_sel_w) bus_rdata_o[0] = gate_q;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_sel_w[c]) begin
        case (ofs_w)
          OFS_STAT:  bus_rdata_o[STAT_W-1:0] = stat_w[c];
          OFS_COUNT: bus_rdata_o[CNT_W-1:0]  = cnt_w[c];
          OFS_LIMIT: bus_rdata_o[CNT_W-1:0]  = limit_w[c];
          default:   ;
        endcase
      end
    end
  end

  p_rd_unmapped_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_sel_w && ch_sel_w == '0) |-> (bus_rdata_o == '0));
  p_gate_closed_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_q && cmd_w == '0) |=> $stable(cnt_w));
endmodule

// File: tb/quad_tick_timer_tb_top.sv
`timescale 1ns/1ps
module quad_tick_timer_tb_top;
  localparam int TB_CNT_W = 8;
  localparam logic [31:0] MASK = (32'h1 << TB_CNT_W) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  tick = '0;
  logic [11:0] addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  quad_tick_timer #(.NUM_CH(4), .CNT_W(TB_CNT_W), .ADDR_W(12), .DATA_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_addr_i(addr),
    .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference model
  logic [31:0] m_cnt [4];
  logic [31:0] m_tc  [4];
  bit m_mode[4], m_en[4], m_ien[4], m_pend[4], m_hit[4];
  bit m_gate, m_gate_old;

  function automatic logic [31:0] m_read(logic [11:0] a);
    logic [31:0] r = '0;
    int c;
    if (a == 12'h100) r = {31'b0, m_gate};
    else if (a < 12'h100) begin
      c = int'(a[7:6]);
      case (a[5:0])
        6'h10: r = {24'b0, m_pend[c], m_ien[c], m_mode[c], m_en[c], m_en[c] ? 4'd2 : 4'd1};
        6'h14: r = m_cnt[c];
        6'h18: r = m_tc[c];
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_cnt[c] = '0; m_tc[c] = MASK; m_mode[c] = 0; m_en[c] = 0; m_ien[c] = 0; m_pend[c] = 0;
      end
      m_gate = 0;
    end else begin
      m_gate_old = m_gate;
      for (int c = 0; c < 4; c++) begin
        m_hit[c] = 0;
        if (tick[c] && m_gate_old && m_en[c]) begin
          if (((m_cnt[c] + 1) & MASK) == m_tc[c]) begin
            m_hit[c] = 1;
            m_pend[c] = 1;
            if (m_mode[c]) begin m_cnt[c] = m_tc[c]; m_en[c] = 0; end
            else m_cnt[c] = '0;
          end else m_cnt[c] = (m_cnt[c] + 1) & MASK;
        end
      end
      if (wr) begin
        if (addr == 12'h100) m_gate = wdata[0];
        else if (addr < 12'h100) begin
          int c;
          c = int'(addr[7:6]);
          case (addr[5:0])
            6'h00: begin m_cnt[c] = '0; m_pend[c] = 0; end
            6'h04: m_en[c] = 1;
            6'h08: m_en[c] = 0;
            6'h0C: m_mode[c] = wdata[0];
            6'h18: m_tc[c] = wdata & MASK;
            6'h1C: m_ien[c] = wdata[0];
            6'h20: if (wdata[7] && !m_hit[c]) m_pend[c] = 0;
            default: ;
          endcase
        end
      end
    end
  end

  // compare against the model on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] exp_irq;
      for (int c = 0; c < 4; c++) exp_irq[c] = m_pend[c] && m_ien[c];
      checks++;
      if (irq !== exp_irq) begin
        errors++;
        $display("FAIL R9 model irq actual=%h expected=%h", irq, exp_irq);
      end
      checks++;
      if (rdata !== m_read(addr)) begin
        errors++;
        $display("FAIL R1 model rdata addr=%h actual=%h expected=%h", addr, rdata, m_read(addr));
      end
    end
  end

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1 addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1 wr = 1'b0; wdata = '0;
  endtask

  task automatic pulse(input int ch, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 tick[ch] = 1'b1;
      @(posedge clk); #1 tick[ch] = 1'b0;
    end
  endtask

  task automatic tick_with_ack(input int ch);
    @(posedge clk); #1 tick[ch] = 1'b1; addr = 12'(ch * 64 + 32); wdata = 32'h80; wr = 1'b1;
    @(posedge clk); #1 tick[ch] = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1 addr = a; wr = 1'b0;
    @(negedge clk);
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdata, exp);
    end
  endtask

  task automatic chk_irq(input logic [3:0] exp, input string tag);
    @(negedge clk);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq actual=%h expected=%h", tag, irq, exp);
    end
  endtask

  initial begin
    #1_600_000;
    errors++;
    $display("FAIL watchdog R3 actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // reset state and map
    chk(12'h010, 32'h01, "R8 reset status");
    chk(12'h018, MASK, "R11 reset limit all ones");
    chk(12'h100, 32'h0, "R12 gate reset");
    chk(12'h024, 32'h0, "R1 unused offset");
    chk(12'h004, 32'h0, "R1 write-only reads zero");
    chk(12'h200, 32'h0, "R1 unmapped");
    // start with odd data, gate closed
    wr_reg(12'h004, 32'hDEAD);
    pulse(0, 3);
    chk(12'h014, 32'h0, "R12 ticks ignored with gate closed");
    chk(12'h010, 32'h12, "R2 start sets run");
    // repeat mode hit
    wr_reg(12'h100, 32'h1);
    wr_reg(12'h018, 32'h3);
    pulse(0, 2);
    chk(12'h014, 32'h2, "R3 count per tick");
    pulse(0, 1);
    chk(12'h014, 32'h0, "R5 restart at zero");
    chk(12'h010, 32'h92, "R5 pending and still running");
    chk_irq(4'b0000, "R9 masked");
    wr_reg(12'h01C, 32'h1);
    chk_irq(4'b0001, "R9 enabled");
    chk(12'h010, 32'hD2, "R8 status with ien");
    // acknowledge
    wr_reg(12'h020, 32'h7F);
    chk(12'h010, 32'hD2, "R10 ack without bit7 ignored");
    wr_reg(12'h020, 32'h80);
    chk(12'h010, 32'h52, "R10 ack clears pending");
    chk_irq(4'b0000, "R10 irq low after ack");
    // stop freezes
    pulse(0, 1);
    wr_reg(12'h008, 32'h0);
    pulse(0, 2);
    chk(12'h014, 32'h1, "R2 stopped count frozen");
    chk(12'h010, 32'h41, "R2 stop clears run");
    // clear keeps config
    wr_reg(12'h004, 32'h0);
    pulse(0, 2);
    chk(12'h010, 32'hD2, "R5 second hit");
    pulse(0, 1);
    wr_reg(12'h000, 32'h0);
    chk(12'h014, 32'h0, "R4 clear zeroes count");
    chk(12'h010, 32'h52, "R4 clear drops pending keeps run and ien");
    chk(12'h018, 32'h3, "R4 clear keeps limit");
    // single-event channel 1 with limit 1
    wr_reg(12'h04C, 32'h1);
    wr_reg(12'h058, 32'h1);
    wr_reg(12'h05C, 32'h1);
    wr_reg(12'h044, 32'h0);
    pulse(1, 1);
    chk(12'h050, 32'hE1, "R7 event after one tick, R6 idle");
    chk(12'h054, 32'h1, "R6 count holds at limit");
    chk_irq(4'b0010, "R9 channel 1 irq");
    pulse(1, 2);
    chk(12'h054, 32'h1, "R6 later ticks ignored");
    chk(12'h014, 32'h0, "R13 channel 0 untouched");
    // acknowledge colliding with a hit
    pulse(0, 2);
    tick_with_ack(0);
    chk(12'h010, 32'hD2, "R10 hit wins over ack");
    wr_reg(12'h020, 32'h80);
    chk(12'h010, 32'h52, "R10 later ack clears");
    // free-running wrap on channel 2
    wr_reg(12'h09C, 32'h1);
    wr_reg(12'h084, 32'h0);
    pulse(2, int'(MASK) - 1);
    chk(12'h094, MASK - 1, "R11 count below wrap");
    pulse(2, 1);
    chk(12'h094, 32'h0, "R11 wraps to zero");
    chk(12'h090, 32'hD2, "R11 pending at wrap");
    pulse(2, 1);
    chk(12'h094, 32'h1, "R11 keeps counting");
    // untouched channel 3 and closed gate
    pulse(3, 3);
    chk(12'h0D4, 32'h0, "R13 channel 3 idle");
    wr_reg(12'h100, 32'h0);
    pulse(2, 2);
    chk(12'h094, 32'h1, "R12 gate closed again");
    chk(12'h100, 32'h0, "R12 gate readback");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule